// File: doc/BRIEF.md
# Segmented Boundary Scan Register for Bidirectional Pads

This block is the boundary scan data register for a bank of programmable, tri-state capable pads. Every pad carries three scan cells: one observes the pad input, one holds the output data and one holds the output enable. Each cell has a shift stage that captures and shifts, and an update stage that holds the value presented to the pad. A test access port controller drives the capture, shift and update strobes and a two-bit mode. A separate pad-disable flag takes every pad off the bus.

Pads are grouped into fixed segments of eight. A segment mask, loaded over its own strobe, decides which segments stay in the serial chain. A deselected segment is skipped by a multiplexer, so it adds no shift cycles, and its cells are frozen. At each segment boundary, and at the serial output, the shift stage launches on the rising clock edge. The next stage takes the value on the falling edge, which makes the chain tolerant of clock skew between segments.

Top module: `bscan_seg_chain`

## Requirements
- R1: An active-low asynchronous reset clears all shift and update cells and the lock-up stages, so `tdo` is low. It also selects every segment.
- R2: With mode 00 (observe), `pad_out` and `pad_oe` follow `core_out` and `core_oe`. A capture loads the scan cells of each selected pad p from its driven state. The cell at chain position 3p takes `pad_in`, 3p+1 takes `pad_out` and 3p+2 takes `pad_oe`. Position 0 is nearest `tdo`, and pad 0 of the lowest selected segment comes first.
- R3: With mode 01 (external test), the update cells drive `pad_out` and `pad_oe`. After an update strobe, pad p takes output data from shifted position 3p+1 and enable from position 3p+2.
- R4: Update cells change only on a rising edge with `upd_en` high. Capture and shifting leave the pads unchanged.
- R5: With mode 10 (clamp), the pads are driven from the update cells. Capture, shift and update strobes do not change those cells.
- R6: With mode 11 (release), every `pad_oe` is low, `pad_out` shows the update cells, and update strobes are ignored.
- R7: `pad_disable` forces every `pad_oe` low in every mode.
- R8: A rising edge with `seg_mask_ld` high loads `seg_mask_in`, where bit s selects pads 8s..8s+7. The chain then spans 24 cells per selected segment, and a bit entering `tdi` leaves `tdo` after that many shifts.
- R9: A deselected segment is neither captured, shifted nor updated, so its pads keep their values.
- R10: With no segment selected, `tdo` equals `tdi` within the same cycle.
- R11: `tdo` changes only on the falling edge of `tck`, so it is stable across the rising edge that shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| cap_en | input | 1 | Capture strobe, takes priority over shift |
| shift_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| mode | input | 2 | 00 observe, 01 external test, 10 clamp, 11 release |
| pad_disable | input | 1 | Forces all output enables low |
| seg_mask_ld | input | 1 | Load strobe for the segment mask |
| seg_mask_in | input | NUM_PADS/8 | New segment mask |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_out | input | NUM_PADS | Output data from the core |
| core_oe | input | NUM_PADS | Output enables from the core |
| pad_in | input | NUM_PADS | Values seen at the pads |
| pad_out | output | NUM_PADS | Output data to the pad drivers |
| pad_oe | output | NUM_PADS | Output enables to the pad drivers |

## Verification
A wrong shift cell or a broken segment link shows at `tdo` on the very shift that brings that position to the output. A scoreboard that predicts every serial bit from the captured pad state catches it within one chain length. An update stage that moves when it should not shows at `pad_out` or `pad_oe` on the next cycle in external test, clamp or release mode. A bad mask path shows as a chain that is one segment too long or too short, because the bench's shifted-in bits then reach `tdo` at the wrong count.

// File: rtl/bscan_seg_pkg.sv
package bscan_seg_pkg;

  localparam int unsigned CELLS_PER_PAD = 3;

  typedef enum logic [1:0] {
    BSM_SAMPLE = 2'b00,
    BSM_EXTEST = 2'b01,
    BSM_CLAMP  = 2'b10,
    BSM_HIGHZ  = 2'b11
  } bsm_mode_e;

  typedef enum logic [1:0] {
    CELL_IN   = 2'd0,
    CELL_DATA = 2'd1,
    CELL_EN   = 2'd2
  } cell_kind_e;

  // position of a cell inside a segment, counted from the tdo end
  function automatic int unsigned cell_pos(int unsigned pad_local, cell_kind_e kind);
    return CELLS_PER_PAD * pad_local + 32'(kind);
  endfunction

  function automatic logic drives_from_update(bsm_mode_e m);
    return m != BSM_SAMPLE;
  endfunction

  function automatic logic update_allowed(bsm_mode_e m);
    return (m == BSM_SAMPLE) || (m == BSM_EXTEST);
  endfunction

  function automatic logic enables_released(bsm_mode_e m, logic disable_all);
    return (m == BSM_HIGHZ) || disable_all;
  endfunction

endpackage

// File: rtl/bscan_seg_group.sv
module bscan_seg_group
  import bscan_seg_pkg::*;
#(
  parameter int unsigned SEG_PADS = 8
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                sel,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic                upd_fire,
  input  logic                si,
  input  logic [SEG_PADS-1:0] pad_in,
  input  logic [SEG_PADS-1:0] drv_out,
  input  logic [SEG_PADS-1:0] drv_oe,
  output logic [SEG_PADS-1:0] upd_out,
  output logic [SEG_PADS-1:0] upd_oe,
  output logic                so
);

  localparam int unsigned SEG_CELLS = CELLS_PER_PAD * SEG_PADS;

  logic [SEG_CELLS-1:0] sr_q;
  logic [SEG_CELLS-1:0] cap_vec;
  logic [SEG_PADS-1:0]  sh_out;
  logic [SEG_PADS-1:0]  sh_oe;

  for (genvar j = 0; j < SEG_PADS; j++) begin : g_pad
    localparam int unsigned P_IN = cell_pos(j, CELL_IN);
    localparam int unsigned P_DA = cell_pos(j, CELL_DATA);
    localparam int unsigned P_EN = cell_pos(j, CELL_EN);
    assign cap_vec[P_IN] = pad_in[j];
    assign cap_vec[P_DA] = drv_out[j];
    assign cap_vec[P_EN] = drv_oe[j];
    assign sh_out[j]     = sr_q[P_DA];
    assign sh_oe[j]      = sr_q[P_EN];
  end

  // shift stage: launches on the rising edge
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (sel && cap_en) begin
      sr_q <= cap_vec;
    end else if (sel && shift_en) begin
      sr_q <= {si, sr_q[SEG_CELLS-1:1]};
    end
  end

  // update stage: holds what the pads see
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      upd_out <= '0;
      upd_oe  <= '0;
    end else if (sel && upd_fire) begin
      upd_out <= sh_out;
      upd_oe  <= sh_oe;
    end
  end

  // lock-up stage: takes the segment tail on the opposite edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) so <= 1'b0;
    else         so <= sr_q[0];
  end

endmodule

// File: rtl/bscan_pad_drive.sv
module bscan_pad_drive
  import bscan_seg_pkg::*;
#(
  parameter int unsigned NUM_PADS = 16
) (
  input  bsm_mode_e           mode,
  input  logic                pad_disable,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  input  logic [NUM_PADS-1:0] upd_out,
  input  logic [NUM_PADS-1:0] upd_oe,
  output logic [NUM_PADS-1:0] drv_out,
  output logic [NUM_PADS-1:0] drv_oe
);

  always_comb begin
    if (drives_from_update(mode)) begin
      drv_out = upd_out;
      drv_oe  = upd_oe;
    end else begin
      drv_out = core_out;
      drv_oe  = core_oe;
    end
    if (enables_released(mode, pad_disable)) drv_oe = '0;
  end

endmodule

// File: rtl/bscan_seg_chain.sv
module bscan_seg_chain
  import bscan_seg_pkg::*;
#(
  parameter int unsigned NUM_PADS = 16,
  parameter int unsigned SEG_PADS = 8
) (
  input  logic                         tck,
  input  logic                         trst_n,
  input  logic                         cap_en,
  input  logic                         shift_en,
  input  logic                         upd_en,
  input  logic [1:0]                   mode,
  input  logic                         pad_disable,
  input  logic                         seg_mask_ld,
  input  logic [NUM_PADS/SEG_PADS-1:0] seg_mask_in,
  input  logic                         tdi,
  output logic                         tdo,
  input  logic [NUM_PADS-1:0]          core_out,
  input  logic [NUM_PADS-1:0]          core_oe,
  input  logic [NUM_PADS-1:0]          pad_in,
  output logic [NUM_PADS-1:0]          pad_out,
  output logic [NUM_PADS-1:0]          pad_oe
);

  localparam int unsigned NUM_SEGS = NUM_PADS / SEG_PADS;

  bsm_mode_e           mode_e;
  logic                upd_fire;
  logic [NUM_SEGS-1:0] seg_mask_q;
  logic [NUM_SEGS-1:0] seg_so;
  logic [NUM_SEGS:0]   link;
  logic [NUM_PADS-1:0] upd_out_all;
  logic [NUM_PADS-1:0] upd_oe_all;
  logic [NUM_PADS-1:0] drv_out;
  logic [NUM_PADS-1:0] drv_oe;

  assign mode_e   = bsm_mode_e'(mode);
  assign upd_fire = upd_en && update_allowed(mode_e);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          seg_mask_q <= '1;
    else if (seg_mask_ld) seg_mask_q <= seg_mask_in;
  end

  assign link[NUM_SEGS] = tdi;

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    bscan_seg_group #(.SEG_PADS(SEG_PADS)) u_grp (
      .tck      (tck),
      .trst_n   (trst_n),
      .sel      (seg_mask_q[s]),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_fire (upd_fire),
      .si       (link[s+1]),
      .pad_in   (pad_in [s*SEG_PADS +: SEG_PADS]),
      .drv_out  (drv_out[s*SEG_PADS +: SEG_PADS]),
      .drv_oe   (drv_oe [s*SEG_PADS +: SEG_PADS]),
      .upd_out  (upd_out_all[s*SEG_PADS +: SEG_PADS]),
      .upd_oe   (upd_oe_all [s*SEG_PADS +: SEG_PADS]),
      .so       (seg_so[s])
    );
    // a deselected segment is a plain wire in the chain
    assign link[s] = seg_mask_q[s] ? seg_so[s] : link[s+1];
  end

  assign tdo = link[0];

  bscan_pad_drive #(.NUM_PADS(NUM_PADS)) u_drive (
    .mode        (mode_e),
    .pad_disable (pad_disable),
    .core_out    (core_out),
    .core_oe     (core_oe),
    .upd_out     (upd_out_all),
    .upd_oe      (upd_oe_all),
    .drv_out     (drv_out),
    .drv_oe      (drv_oe)
  );

  assign pad_out = drv_out;
  assign pad_oe  = drv_oe;

endmodule

// File: rtl/bscan_seg_chain_chk.sv
module bscan_seg_chain_chk #(
  parameter int unsigned NUM_PADS = 16,
  parameter int unsigned NUM_SEGS = 2
) (
  input logic                tck,
  input logic                trst_n,
  input logic                upd_fire,
  input logic [1:0]          mode,
  input logic                pad_disable,
  input logic [NUM_SEGS-1:0] seg_mask_q,
  input logic                tdi,
  input logic                tdo,
  input logic [NUM_PADS-1:0] core_out,
  input logic [NUM_PADS-1:0] core_oe,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] upd_out_all,
  input logic [NUM_PADS-1:0] upd_oe_all
);

  assert_sample_pass_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'b00 && !pad_disable) |-> (pad_out == core_out && pad_oe == core_oe));

  assert_extest_drive_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'b01 && !pad_disable) |-> (pad_out == upd_out_all && pad_oe == upd_oe_all));

  assert_update_hold_R4: assert property (@(posedge tck) disable iff (!trst_n)
    !$past(upd_fire) |-> $stable({upd_out_all, upd_oe_all}));

  assert_clamp_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
    $past(mode == 2'b10) |-> $stable({upd_out_all, upd_oe_all}));

  assert_release_oe_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 2'b11) |-> (pad_oe == '0));

  assert_disable_oe_R7: assert property (@(posedge tck) disable iff (!trst_n)
    pad_disable |-> (pad_oe == '0));

  assert_bypass_wire_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (seg_mask_q == '0) |-> (tdo == tdi));

endmodule

bind bscan_seg_chain bscan_seg_chain_chk #(
  .NUM_PADS (NUM_PADS),
  .NUM_SEGS (NUM_PADS / SEG_PADS)
) u_chk (
  .tck         (tck),
  .trst_n      (trst_n),
  .upd_fire    (upd_fire),
  .mode        (mode),
  .pad_disable (pad_disable),
  .seg_mask_q  (seg_mask_q),
  .tdi         (tdi),
  .tdo         (tdo),
  .core_out    (core_out),
  .core_oe     (core_oe),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .upd_out_all (upd_out_all),
  .upd_oe_all  (upd_oe_all)
);

// File: tb/test_bscan_seg_chain.sv
module test_bscan_seg_chain;

  localparam int NP = 16;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          pad_disable = 1'b0;
  logic          seg_mask_ld = 1'b0;
  logic [1:0]    seg_mask_in = 2'b11;
  logic          tdi = 1'b0;
  logic          tdo;
  logic [NP-1:0] core_out = 16'hA5C3, core_oe = 16'h0FF0, pad_in = 16'h3C5A;
  logic [NP-1:0] pad_out, pad_oe;

  bscan_seg_chain #(.NUM_PADS(NP), .SEG_PADS(8)) i_bscan_seg_chain (
    .tck(tck), .trst_n(trst_n), .cap_en(cap_en), .shift_en(shift_en),
    .upd_en(upd_en), .mode(mode), .pad_disable(pad_disable),
    .seg_mask_ld(seg_mask_ld), .seg_mask_in(seg_mask_in), .tdi(tdi), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #10 tck = ~tck;

  int    checks = 0;
  int    errors = 0;
  logic  exp_q[$];
  string cur_req = "R2";
  logic  mon_on = 1'b1;
  logic  done = 1'b0;
  logic [NP-1:0] m_uo = '0, m_uoe = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected tdo bit ahead of every shifting edge
  always @(negedge tck) begin
    #5;
    if (mon_on && shift_en) begin
      if (exp_q.size() == 0) chk(cur_req, {63'd0, tdo}, 64'hx);
      else chk(cur_req, {63'd0, tdo}, {63'd0, exp_q.pop_front()});
    end
  end

  task automatic tick();
    @(posedge tck); #2;
  endtask

  function automatic logic [47:0] cap_bits(input logic [NP-1:0] pi, po, pe);
    logic [47:0] b;
    for (int p = 0; p < NP; p++) begin
      b[3*p]   = pi[p];
      b[3*p+1] = po[p];
      b[3*p+2] = pe[p];
    end
    return b;
  endfunction

  task automatic push_bits(input int n, input logic [63:0] v);
    for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
  endtask

  task automatic capture();
    cap_en = 1'b1; tick(); cap_en = 1'b0;
  endtask

  task automatic update();
    upd_en = 1'b1; tick(); upd_en = 1'b0;
  endtask

  task automatic scan(input int n, input logic [63:0] din, input string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      shift_en = 1'b1; tdi = din[i]; tick();
    end
    shift_en = 1'b0; tdi = 1'b0;
    if (mon_on) chk(req, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic load_model(input int first, input int n, input logic [63:0] v, input int off);
    for (int j = 0; j < n; j++) begin
      m_uo[first+j]  = v[3*j+1+off];
      m_uoe[first+j] = v[3*j+2+off];
    end
  endtask

  task automatic load_mask(input logic [1:0] m);
    seg_mask_in = m; seg_mask_ld = 1'b1; tick(); seg_mask_ld = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, e, f, g, h, jv, k;
    logic [47:0] cb;
    d  = 64'h0000_9A3C_51E7_0B6D;
    e  = 64'h0000_6E2B_D914_A7C5;
    f  = 64'h0000_FFFF_0000_FFFF;
    g  = 64'h0000_5555_AAAA_3333;
    h  = 64'h0000_3B7D_E2C9_146F;
    jv = 64'h0000_0000_C3A5_96E1;
    k  = 64'h0000_1234_5678_9AB5;

    repeat (3) tick();
    trst_n = 1'b1;
    tick();

    // R1: cleared cells, low tdo
    chk("R1", {63'd0, tdo}, 64'd0);
    chk("R2", 64'(pad_out), 64'(core_out));
    chk("R2", 64'(pad_oe), 64'(core_oe));
    mode = 2'b01; #1;
    chk("R1", 64'({pad_out, pad_oe}), 64'd0);
    mode = 2'b00; #1;

    // R2: capture in observe mode, preload
    push_bits(48, 64'(cap_bits(pad_in, core_out, core_oe)));
    capture();
    scan(48, d, "R2");
    chk("R4", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
    update();
    load_model(0, NP, d, 0);
    chk("R2", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));

    // R3: external test drives preloaded values
    mode = 2'b01; #1;
    chk("R3", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));
    pad_in = 16'hF00F;
    push_bits(48, 64'(cap_bits(pad_in, m_uo, m_uoe)));
    capture();
    scan(48, e, "R3");
    chk("R4", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));
    update();
    load_model(0, NP, e, 0);
    chk("R3", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));

    // R5: clamp freezes update cells
    mode = 2'b10; #1;
    chk("R5", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));
    pad_in = 16'h1234;
    push_bits(48, 64'(cap_bits(pad_in, m_uo, m_uoe)));
    capture();
    scan(48, f, "R5");
    update();
    chk("R5", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));

    // R6: release mode
    mode = 2'b11; #1;
    chk("R6", 64'(pad_oe), 64'd0);
    chk("R6", 64'(pad_out), 64'(m_uo));
    push_bits(48, 64'(cap_bits(pad_in, m_uo, 16'h0000)));
    capture();
    scan(48, g, "R6");
    update();
    mode = 2'b01; #1;
    chk("R6", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));

    // R7: disable overrides enables in every mode
    pad_disable = 1'b1; #1;
    chk("R7", 64'(pad_oe), 64'd0);
    chk("R7", 64'(pad_out), 64'(m_uo));
    mode = 2'b00; #1;
    chk("R7", 64'(pad_oe), 64'd0);
    chk("R7", 64'(pad_out), 64'(core_out));
    pad_disable = 1'b0; mode = 2'b01; #1;

    // R8: only upper segment, 24-cell chain
    load_mask(2'b10);
    cb = cap_bits(pad_in, m_uo, m_uoe);
    push_bits(24, 64'(cb[47:24]));
    push_bits(6, h);
    capture();
    scan(30, h, "R8");
    update();
    load_model(8, 8, h, 6);
    chk("R8", 64'({pad_out[15:8], pad_oe[15:8]}), 64'({m_uo[15:8], m_uoe[15:8]}));
    chk("R9", 64'({pad_out[7:0], pad_oe[7:0]}), 64'({m_uo[7:0], m_uoe[7:0]}));

    // R8/R9: only lower segment
    load_mask(2'b01);
    cb = cap_bits(pad_in, m_uo, m_uoe);
    push_bits(24, 64'(cb[23:0]));
    capture();
    scan(24, jv, "R8");
    update();
    load_model(0, 8, jv, 0);
    chk("R9", 64'({pad_out[15:8], pad_oe[15:8]}), 64'({m_uo[15:8], m_uoe[15:8]}));
    chk("R8", 64'({pad_out[7:0], pad_oe[7:0]}), 64'({m_uo[7:0], m_uoe[7:0]}));

    // R10: empty chain is a wire
    load_mask(2'b00);
    tdi = 1'b1; #1;
    chk("R10", {63'd0, tdo}, 64'd1);
    tdi = 1'b0; #1;
    chk("R10", {63'd0, tdo}, 64'd0);
    push_bits(8, 64'hB6);
    capture();
    scan(8, 64'hB6, "R10");
    update();
    chk("R9", 64'({pad_out, pad_oe}), 64'({m_uo, m_uoe}));

    // R11: tdo moves on the falling edge only
    load_mask(2'b11);
    mon_on = 1'b0;
    scan(48, k, "R11");
    #13;
    chk("R11", {63'd0, tdo}, {63'd0, k[0]});
    shift_en = 1'b1;
    @(posedge tck); #2;
    shift_en = 1'b0;
    chk("R11", {63'd0, tdo}, {63'd0, k[0]});
    #10;
    chk("R11", {63'd0, tdo}, {63'd0, k[1]});
    tick();
    mon_on = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule